// File: doc/BRIEF.md
# Interrupt Aggregator with Wakeup Select

This block gathers interrupt lines from many sensors into one vector and hands that vector to the host in two ways. First, every line passes through a two-flop synchroniser. The synchronised vector is then written, every cycle, into one half of a two-bank buffer. The other half stays frozen so that it can be read. When the host pulses a start request, the frozen half is copied into a shift register and sent out serially on an SPI channel that carries nothing but interrupt data. The two halves trade roles only when a frame has finished. A frame never sees a bank change under it.

Second, a small configuration register selects one line of the vector and drives the CPU wakeup pin from it as a level. The same register holds a test bit, which enters the vector as its top line. Software can therefore raise an interrupt on its own, watch it appear in the serial frame, and use it to wake the CPU.

The vector is `N_IRQ` lines wide (80 by default). The lower `N_IRQ-1` lines come from the `irq_in` pins and the top line is the test bit.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the synchroniser, both buffer banks, the select field (to 0), the test bit and the bank index. After reset `irq_spi_cs_n`=1, `irq_spi_sck`=0, `irq_spi_mosi`=0, `irq_buf_idx`=0 and `wake_o`=0.
- R2: A change on any interrupt line passes through two synchroniser flops and a registered wakeup output. When the line is selected, `wake_o` follows it exactly three clock edges later.
- R3: Vector layout: bit i for i in 0..N_IRQ-2 is `irq_in[i]`, and bit N_IRQ-1 is the test bit. A frame sends bit N_IRQ-1 first and bit 0 last.
- R4: A `rd_start` seen at an edge while the channel is idle starts a frame. From the next cycle `irq_spi_cs_n` is low for exactly 2*N_IRQ cycles. Each bit takes two cycles, with `irq_spi_sck` low in the first and high in the second, and `irq_spi_mosi` holds the bit across both.
- R5: A `rd_start` that arrives while a frame is in progress, including at the edge that ends it, is ignored. The frame in progress keeps its length and its content.
- R6: Each frame carries the synchronised vector as it stood at the edge that ended the previous frame, or all zeros for the first frame after reset. Input changes during a frame never alter that frame. `irq_buf_idx` toggles at the edge that ends each frame.
- R7: `wake_o` follows the vector line whose index equals the select field, for index 0..N_IRQ-1. A select value of N_IRQ or more, including all ones (127 by default), holds `wake_o` low.
- R8: The configuration register is loaded only at an edge where `cfg_we` is high. At that edge `cfg_wdata[6:0]` becomes the select field and `cfg_wdata[7]` becomes the test bit. When `cfg_we` is low, changes on `cfg_wdata` have no effect.
- R9: Setting the test bit raises vector line N_IRQ-1. This shows in the next frame captured after it, and it drives `wake_o` high when the select field is N_IRQ-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N_IRQ-1 | Asynchronous interrupt lines from the sensors |
| cfg_we | input | 1 | Clock enable for a configuration register write |
| cfg_wdata | input | SEL_W+1 | Write data: top bit is the test bit, the rest is the wakeup select |
| rd_start | input | 1 | Request to send the frozen vector |
| irq_spi_cs_n | output | 1 | Frame select of the interrupt SPI channel, active low |
| irq_spi_sck | output | 1 | Serial clock, half the core clock rate |
| irq_spi_mosi | output | 1 | Serial data, most significant vector bit first |
| irq_buf_idx | output | 1 | Index of the bank currently frozen for read-out |
| wake_o | output | 1 | Level wakeup to the CPU |

## Verification
A bank index that flips at the wrong time shows up in the next frame, which then carries either stale data or data that changed mid-frame. That is visible on `irq_spi_mosi` within 2*N_IRQ cycles of the wrong flip, and on `irq_buf_idx` at once. A wrong select or test-bit state shows on `wake_o` within three cycles of the first input pattern that tells the lines apart. A miscounted bit counter stretches or shortens the low phase of `irq_spi_cs_n`, and the first frame exposes it. Because of this, the reference model is compared against all five outputs on every cycle while inputs, configuration writes and start requests change at random, including start requests in the middle of a frame.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    SO_IDLE  = 1'b0,
    SO_SHIFT = 1'b1
  } so_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= raw_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irq_dbuf.sv
module irq_dbuf #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         swap_i,
  input  logic [W-1:0] din_i,
  output logic         idx_o,
  output logic [W-1:0] rd_vec_o
);
  logic idx_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= 1'b0;
    else if (swap_i) idx_q <= ~idx_q;
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                 q <= '0;
      else if (idx_q != 1'(g)) q <= din_i;
    end
  end

  assign rd_vec_o = idx_q ? g_bank[1].q : g_bank[0].q;
  assign idx_o    = idx_q;

  p_rdbuf_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !swap_i |=> $stable(rd_vec_o));
  p_idx_flip_r6: assert property (@(posedge clk) disable iff (rst)
    swap_i |=> (idx_o != $past(idx_o)));
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !swap_i |=> $stable(idx_o));
endmodule

// File: rtl/irq_ser_out.sv
module irq_ser_out
  import irq_agg_pkg::*;
#(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  output logic         cs_n_o,
  output logic         sck_o,
  output logic         mosi_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(2 * W);
  localparam logic [CNT_W-1:0] LAST_H = CNT_W'(2 * W - 1);

  so_state_e        state_q;
  logic [CNT_W-1:0] hcnt_q;
  logic [W-1:0]     shreg_q;

  function automatic logic high_phase(input logic [CNT_W-1:0] h);
    return h[0];
  endfunction

  assign done_o = (state_q == SO_SHIFT) && (hcnt_q == LAST_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SO_IDLE;
      hcnt_q  <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        SO_IDLE: begin
          if (start_i) begin
            state_q <= SO_SHIFT;
            hcnt_q  <= '0;
            shreg_q <= load_i;
          end
        end
        default: begin
          if (done_o) state_q <= SO_IDLE;
          else        hcnt_q  <= hcnt_q + CNT_W'(1);
          if (high_phase(hcnt_q)) shreg_q <= {shreg_q[W-2:0], 1'b0};
        end
      endcase
    end
  end

  assign cs_n_o = (state_q == SO_IDLE);
  assign sck_o  = (state_q == SO_SHIFT) && high_phase(hcnt_q);
  assign mosi_o = (state_q == SO_SHIFT) && shreg_q[W-1];

  p_cs_sck_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> $stable(mosi_o));
  p_done_ends_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> cs_n_o);
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !done_o) |=> !cs_n_o);
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int SEL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [SEL_W:0]   wdata_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             tst_o
);
  logic [SEL_W-1:0] sel_q;
  logic             tst_q;

  function automatic logic [SEL_W-1:0] sel_field(input logic [SEL_W:0] d);
    return d[SEL_W-1:0];
  endfunction

  function automatic logic tst_field(input logic [SEL_W:0] d);
    return d[SEL_W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      tst_q <= 1'b0;
    end else if (we_i) begin
      sel_q <= sel_field(wdata_i);
      tst_q <= tst_field(wdata_i);
    end
  end

  assign sel_o = sel_q;
  assign tst_o = tst_q;

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(sel_o) && $stable(tst_o)));
  p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (sel_o == $past(wdata_i[SEL_W-1:0])));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_IRQ = 80,
  parameter int SEL_W = $clog2(N_IRQ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-2:0] irq_in,
  input  logic             cfg_we,
  input  logic [SEL_W:0]   cfg_wdata,
  input  logic             rd_start,
  output logic             irq_spi_cs_n,
  output logic             irq_spi_sck,
  output logic             irq_spi_mosi,
  output logic             irq_buf_idx,
  output logic             wake_o
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_IRQ - 1);

  logic [SEL_W-1:0] sel_w;
  logic             tst_w;
  logic [N_IRQ-1:0] raw_vec_w;
  logic [N_IRQ-1:0] sync_vec_w;
  logic [N_IRQ-1:0] frozen_vec_w;
  logic             frame_done_w;
  logic             wake_q;

  function automatic logic pick_line(input logic [N_IRQ-1:0] v,
                                     input logic [SEL_W-1:0] s);
    if (s <= LAST_SEL) return v[s];
    return 1'b0;
  endfunction

  assign raw_vec_w = {tst_w, irq_in};

  irq_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .sel_o(sel_w), .tst_o(tst_w)
  );

  irq_sync #(.W(N_IRQ)) u_sync (
    .clk(clk), .rst(rst), .raw_i(raw_vec_w), .sync_o(sync_vec_w)
  );

  irq_dbuf #(.W(N_IRQ)) u_dbuf (
    .clk(clk), .rst(rst), .swap_i(frame_done_w), .din_i(sync_vec_w),
    .idx_o(irq_buf_idx), .rd_vec_o(frozen_vec_w)
  );

  irq_ser_out #(.W(N_IRQ)) u_ser (
    .clk(clk), .rst(rst), .start_i(rd_start), .load_i(frozen_vec_w),
    .cs_n_o(irq_spi_cs_n), .sck_o(irq_spi_sck), .mosi_o(irq_spi_mosi),
    .done_o(frame_done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= pick_line(sync_vec_w, sel_w);
  end

  assign wake_o = wake_q;

  p_wake_off_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_w > LAST_SEL) |=> !wake_o);
  p_test_wake_r9: assert property (@(posedge clk) disable iff (rst)
    ((sel_w == LAST_SEL) && $stable(sel_w) && sync_vec_w[N_IRQ-1]) |=> wake_o);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int N = 80;
  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-2:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [SW:0]   cfg_wdata = '0;
  logic          rd_start = 1'b0;
  logic          cs_n, sck, mosi, bidx, wake;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_aggregator #(.N_IRQ(N)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_start(rd_start),
    .irq_spi_cs_n(cs_n), .irq_spi_sck(sck), .irq_spi_mosi(mosi),
    .irq_buf_idx(bidx), .wake_o(wake)
  );

  // Behavioural reference: history of raw vectors, frozen snapshot, frame timer
  logic [N-1:0] hist[$];
  logic [N-1:0] seen, m_rb, m_bits;
  int  m_sel, m_cyc;
  bit  m_tst, m_idx, m_busy, m_wake;

  always @(posedge clk) begin
    if (rst) begin
      hist = {};
      hist.push_back('0);
      hist.push_back('0);
      m_sel = 0; m_tst = 0; m_rb = '0; m_bits = '0;
      m_idx = 0; m_busy = 0; m_cyc = 0; m_wake = 0;
    end else begin
      seen = hist[0];
      m_wake = (m_sel < N) ? seen[m_sel] : 1'b0;
      if (m_busy) begin
        m_cyc++;
        if (m_cyc == 2 * N) begin
          m_busy = 0;
          m_rb = seen;
          m_idx = !m_idx;
        end
      end else if (rd_start) begin
        m_busy = 1;
        m_cyc = 0;
        m_bits = m_rb;
      end
      void'(hist.pop_front());
      hist.push_back({m_tst, irq_in});
      if (cfg_we) begin
        m_sel = int'(cfg_wdata[SW-1:0]);
        m_tst = cfg_wdata[SW];
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R4 cs_n", cs_n, !m_busy);
      chk("R4 sck", sck, m_busy && (m_cyc % 2 == 1));
      chk("R3 mosi", mosi, m_busy ? m_bits[N - 1 - m_cyc / 2] : 1'b0);
      chk("R6 buf_idx", bidx, m_idx);
      chk("R7 wake", wake, m_wake);
    end
  end

  task automatic write_cfg(input int sel, input bit tst);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {tst, SW'(sel)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [N-2:0] rand_vec();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[N-2:0];
  endfunction

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1'b1);
    chk("R1 reset sck", sck, 1'b0);
    chk("R1 reset mosi", mosi, 1'b0);
    chk("R1 reset idx", bidx, 1'b0);
    chk("R1 reset wake", wake, 1'b0);
    rst = 1'b0;
    cmp_on = 1;

    // R2: line 0 is selected after reset; three-edge latency
    irq_in[0] = 1'b1;
    @(negedge clk); chk("R2 wake not yet (1)", wake, 1'b0);
    @(negedge clk); chk("R2 wake not yet (2)", wake, 1'b0);
    @(negedge clk); chk("R2 wake at third edge", wake, 1'b1);

    // R6: first frame after reset is all zeros even though inputs are set
    irq_in = rand_vec() | 79'h1;
    rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    ones = 0;
    for (int i = 0; i < 2 * N; i++) begin
      if (mosi) ones++;
      @(negedge clk);
    end
    n_tests++;
    if (ones != 0) begin
      n_fail++;
      $display("FAIL R6 first frame: actual %0d ones expected 0", ones);
    end

    // R9: test bit drives wake through select N-1
    irq_in = '0;
    write_cfg(N - 1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 test bit wakes", wake, 1'b1);
    write_cfg(N - 1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 test bit cleared", wake, 1'b0);

    // R7: out-of-range selects hold wake low with all lines high
    irq_in = '1;
    write_cfg(127, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 select all ones", wake, 1'b0);
    write_cfg(N + 5, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 select above range", wake, 1'b0);

    // R8: data without enable changes nothing
    cfg_wdata = {1'b1, SW'(3)};
    repeat (5) @(negedge clk);
    chk("R8 ignored write", wake, 1'b0);

    // Random traffic: inputs, config writes, start requests incl. mid-frame (R5)
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) irq_in = rand_vec();
      rd_start = ($urandom % 12 == 0);
      cfg_we = ($urandom % 40 == 0);
      case ($urandom % 4)
        0: cfg_wdata = {1'($urandom), SW'(N - 1)};
        1: cfg_wdata = {1'($urandom), SW'(127)};
        default: cfg_wdata = {1'($urandom), SW'($urandom % N)};
      endcase
    end
    rd_start = 1'b0;
    cfg_we = 1'b0;
    repeat (2 * N + 4) @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule